// File: doc/BRIEF.md
# Bit-Serial Keystream XOR Stage

This block turns plaintext bytes into a ciphertext bit stream. A host pushes plaintext bytes into a small byte queue ahead of time. A keystream generator offers one keystream byte at a time with a valid/ready handshake. When a byte can be accepted, the head of the queue and the offered keystream byte are loaded together into two parallel-to-serial shift registers. On each following clock, one bit of each shifter is combined by XOR and presented as one ciphertext bit.

An end-of-conversion pulse marks the last bit of each byte. The next pair can be loaded during that last bit, so a steady supply of bytes gives an unbroken bit stream. Because XOR is its own inverse, the same block decrypts when fed ciphertext bytes. The queue reports full and empty. A host write that arrives while the queue is full is discarded and reported on the next cycle.

Top module: `bitser_xor_cipher`

## Requirements
- R1: After reset the queue is empty (`pt_empty`=1, `pt_full`=0), and `ct_valid`, `ct_bit`, `eoc` and `pt_drop` are all 0.
- R2: The queue holds up to `FIFO_DEPTH` (default 8) bytes. `pt_full` is 1 exactly when it holds that many, and `pt_empty` is 1 exactly when it holds none. A write that is accepted in a cycle takes effect at that clock edge.
- R3: A write (`pt_wr`=1) while `pt_full`=1 leaves the queue contents unchanged, and `pt_drop` is 1 in the following cycle. `pt_drop` is 0 in every other cycle.
- R4: `ks_ready` is 1 exactly when the queue is non-empty and no byte is shifting, or when the byte in progress is on its last bit. A load happens at a clock edge where `ks_valid` and `ks_ready` are both 1.
- R5: A load takes the queue head and the offered `ks_data` at the same edge, and plaintext bytes are consumed in the order they were written.
- R6: After a load, `ct_valid` is 1 for `BYTE_W` consecutive cycles, starting one cycle after the load edge. `ct_bit` in the n-th of those cycles is plaintext bit (BYTE_W-1-n) XOR keystream bit (BYTE_W-1-n), so the most significant bit comes first with the default order.
- R7: `eoc` is 1 only in the cycle that carries the last bit of a byte, and it is 1 once for every byte.
- R8: If a load happens on the last bit of a byte, `ct_valid` stays 1 with no idle cycle between the two bytes.
- R9: While `ct_valid` is 0, `ct_bit` and `eoc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_wr | input | 1 | Host write strobe for a plaintext byte |
| pt_data | input | BYTE_W | Plaintext byte to enqueue |
| pt_full | output | 1 | Queue holds FIFO_DEPTH bytes |
| pt_empty | output | 1 | Queue holds no bytes |
| pt_drop | output | 1 | Previous cycle's write was discarded because the queue was full |
| ks_valid | input | 1 | Keystream byte offered |
| ks_data | input | BYTE_W | Keystream byte |
| ks_ready | output | 1 | Stage can load a pair this cycle |
| ct_bit | output | 1 | Ciphertext bit |
| ct_valid | output | 1 | `ct_bit` carries a live bit |
| eoc | output | 1 | Last bit of the current byte |

## Verification
The bound checker watches several rules on every cycle. It checks that the full and empty flags never coincide and that a drop report follows exactly the full-queue writes. It also checks that a load is refused while a byte is in mid-shift, that a load produces a live bit on the next cycle, that the output bit stays quiet when no byte is live, and that the end-of-conversion pulse lands on every `BYTE_W`-th live bit. Only the bench's scenarios can show the actual ciphertext values. They also show that bytes leave the queue in write order paired with the right keystream byte, that discarded bytes never reach the output, and that chained loads close every gap. For this the bench sweeps all 256 plaintext values against an odd-stride keystream, under both steady and gapped keystream supply.

// File: rtl/bxc_pkg.sv
package bxc_pkg;

   // order in which a loaded byte leaves the shifters
   typedef enum logic {
      ORDER_LSB = 1'b0,
      ORDER_MSB = 1'b1
   } bit_order_e;

   // number of shift lanes: plaintext lane and keystream lane
   localparam int unsigned LANES    = 2;
   localparam int unsigned LANE_PT  = 0;
   localparam int unsigned LANE_KS  = 1;

endpackage

// File: rtl/bxc_fifo.sv
module bxc_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             full,
   output logic             empty,
   output logic             drop
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("bxc_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;
   logic             do_wr, do_rd;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_wr   = wr_en & ~full;
   assign do_rd   = rd_en & ~empty;
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_wr) begin
         mem[wr_ptr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         drop   <= 1'b0;
      end else begin
         drop <= wr_en & full;
         if (do_wr) begin
            wr_ptr <= wr_ptr + AW'(1);
         end
         if (do_rd) begin
            rd_ptr <= rd_ptr + AW'(1);
         end
         case ({do_wr, do_rd})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/bxc_shifter.sv
module bxc_shifter #(
   parameter int unsigned          WIDTH = 8,
   parameter bxc_pkg::bit_order_e  ORDER = bxc_pkg::ORDER_MSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   input  logic             shift,
   output logic             bit_out
);

   logic [WIDTH-1:0] sh_q;
   logic [WIDTH-1:0] sh_next;

   generate
      if (ORDER == bxc_pkg::ORDER_MSB) begin : g_msb
         assign sh_next = {sh_q[WIDTH-2:0], 1'b0};
         assign bit_out = sh_q[WIDTH-1];
      end else begin : g_lsb
         assign sh_next = {1'b0, sh_q[WIDTH-1:1]};
         assign bit_out = sh_q[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= din;
      end else if (shift) begin
         sh_q <= sh_next;
      end
   end

endmodule

// File: rtl/bxc_bitcount.sv
module bxc_bitcount #(
   parameter int unsigned WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy,
   output logic last
);

   localparam int unsigned CW = $clog2(WIDTH + 1);

   logic [CW-1:0] remain;

   assign busy = (remain != '0);
   assign last = (remain == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= CW'(WIDTH);
      end else if (busy) begin
         remain <= remain - CW'(1);
      end
   end

endmodule

// File: rtl/bitser_xor_cipher.sv
module bitser_xor_cipher #(
   parameter int unsigned         BYTE_W     = 8,
   parameter int unsigned         FIFO_DEPTH = 8,
   parameter bxc_pkg::bit_order_e ORDER      = bxc_pkg::ORDER_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pt_wr,
   input  logic [BYTE_W-1:0] pt_data,
   output logic              pt_full,
   output logic              pt_empty,
   output logic              pt_drop,
   input  logic              ks_valid,
   input  logic [BYTE_W-1:0] ks_data,
   output logic              ks_ready,
   output logic              ct_bit,
   output logic              ct_valid,
   output logic              eoc
);

   import bxc_pkg::*;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("bitser_xor_cipher: BYTE_W must be at least 2");
      end
   endgenerate

   logic [BYTE_W-1:0] head_byte;
   logic              busy, last, load;
   logic [BYTE_W-1:0] lane_din [LANES];
   logic [LANES-1:0]  lane_bit;

   bxc_fifo #(
      .WIDTH (BYTE_W),
      .DEPTH (FIFO_DEPTH)
   ) fifo_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pt_wr),
      .wr_data (pt_data),
      .rd_en   (load),
      .rd_data (head_byte),
      .full    (pt_full),
      .empty   (pt_empty),
      .drop    (pt_drop)
   );

   bxc_bitcount #(
      .WIDTH (BYTE_W)
   ) count_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .busy  (busy),
      .last  (last)
   );

   assign ks_ready = ~pt_empty & (~busy | last);
   assign load     = ks_valid & ks_ready;

   assign lane_din[LANE_PT] = head_byte;
   assign lane_din[LANE_KS] = ks_data;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      bxc_shifter #(
         .WIDTH (BYTE_W),
         .ORDER (ORDER)
      ) shift_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (load),
         .din     (lane_din[g]),
         .shift   (busy),
         .bit_out (lane_bit[g])
      );
   end

   assign ct_valid = busy;
   assign ct_bit   = busy & (^lane_bit);
   assign eoc      = last;

endmodule

// File: rtl/bxc_checker.sv
module bxc_checker #(
   parameter int unsigned BYTE_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic pt_wr,
   input logic pt_full,
   input logic pt_empty,
   input logic pt_drop,
   input logic ks_valid,
   input logic ks_ready,
   input logic ct_bit,
   input logic ct_valid,
   input logic eoc
);

   localparam int unsigned PW = $clog2(BYTE_W);

   // live-bit position inside the current byte, counted independently
   logic [PW-1:0] pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (ct_valid) begin
         pos <= eoc ? '0 : pos + PW'(1);
      end
   end

   assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(pt_full && pt_empty));

   assert_drop_reported_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_wr && pt_full) |=> pt_drop);

   assert_no_spurious_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(pt_wr && pt_full) |=> !pt_drop);

   assert_ready_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ks_ready |-> !pt_empty);

   assert_no_load_midbyte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ct_valid && !eoc) |-> !ks_ready);

   assert_load_starts_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ks_valid && ks_ready) |=> ct_valid);

   assert_eoc_position_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ct_valid |-> (eoc == (pos == PW'(BYTE_W - 1))));

   assert_stream_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && !(ks_valid && ks_ready)) |=> !ct_valid);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ct_valid |-> (!ct_bit && !eoc));

endmodule

bind bitser_xor_cipher bxc_checker #(.BYTE_W(BYTE_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .pt_wr    (pt_wr),
   .pt_full  (pt_full),
   .pt_empty (pt_empty),
   .pt_drop  (pt_drop),
   .ks_valid (ks_valid),
   .ks_ready (ks_ready),
   .ct_bit   (ct_bit),
   .ct_valid (ct_valid),
   .eoc      (eoc)
);

// File: tb/bitser_xor_cipher_tb_top.sv
`timescale 1ns/100ps
module bitser_xor_cipher_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pt_wr = 1'b0;
   logic [7:0] pt_data = '0;
   logic       pt_full, pt_empty, pt_drop;
   logic       ks_valid = 1'b0;
   logic [7:0] ks_data = '0;
   logic       ks_ready, ct_bit, ct_valid, eoc;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   bitser_xor_cipher dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pt_wr    (pt_wr),
      .pt_data  (pt_data),
      .pt_full  (pt_full),
      .pt_empty (pt_empty),
      .pt_drop  (pt_drop),
      .ks_valid (ks_valid),
      .ks_data  (ks_data),
      .ks_ready (ks_ready),
      .ct_bit   (ct_bit),
      .ct_valid (ct_valid),
      .eoc      (eoc)
   );

   // bench reference model state
   logic [7:0] q [$];
   logic [7:0] cur = '0;
   bit         act = 1'b0;
   int         bpos = 0;
   bit         drop_exp = 1'b0;
   bit         chained = 1'b0;
   int         kidx = 0;
   int         bytes_out = 0;

   function automatic logic [7:0] ks_fn(input int k);
      return 8'((k * 29 + 7) & 255);
   endfunction

   task automatic chk(input string tag, input int act_v, input int exp_v);
      tests++;
      if (act_v != exp_v) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act_v, exp_v, $time);
      end
   endtask

   task automatic step(input bit wr, input logic [7:0] wd, input bit kv);
      bit rdy_exp, was_last, full_b;
      @(negedge clk);
      rdy_exp  = (q.size() != 0) && (!act || bpos == 7);
      was_last = act && (bpos == 7);
      chk("R4 ks_ready", int'(ks_ready), int'(rdy_exp));
      chk("R2 pt_full", int'(pt_full), int'(q.size() == 8));
      chk("R2 pt_empty", int'(pt_empty), int'(q.size() == 0));
      chk("R3 pt_drop", int'(pt_drop), int'(drop_exp));
      chk("R6 ct_valid", int'(ct_valid), int'(act));
      if (chained) chk("R8 no gap", int'(ct_valid), 1);
      chained = 1'b0;
      if (act) begin
         chk("R5 R6 ct_bit", int'(ct_bit), int'(cur[7 - bpos]));
         chk("R7 eoc", int'(eoc), int'(bpos == 7));
         bpos++;
         if (bpos == 8) begin
            act  = 1'b0;
            bpos = 0;
            bytes_out++;
         end
      end else begin
         chk("R9 idle ct_bit", int'(ct_bit), 0);
         chk("R9 idle eoc", int'(eoc), 0);
      end
      pt_wr    = wr;
      pt_data  = wd;
      ks_valid = kv;
      ks_data  = ks_fn(kidx);
      full_b   = (q.size() == 8);
      drop_exp = wr && full_b;
      if (kv && rdy_exp) begin
         cur = q.pop_front() ^ ks_fn(kidx);
         kidx++;
         act  = 1'b1;
         bpos = 0;
         chained = was_last;
      end
      if (wr && !full_b) q.push_back(wd);
   endtask

   initial begin
      int wcount;
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pt_empty", int'(pt_empty), 1);
      chk("R1 pt_full", int'(pt_full), 0);
      chk("R1 ct_valid", int'(ct_valid), 0);
      chk("R1 ct_bit", int'(ct_bit), 0);
      chk("R1 eoc", int'(eoc), 0);
      chk("R1 pt_drop", int'(pt_drop), 0);

      // fill the queue with no keystream, then overflow it twice (R2, R3)
      for (int i = 0; i < 8; i++) step(1'b1, 8'(8'hA0 + i), 1'b0);
      step(1'b1, 8'hEE, 1'b0);
      step(1'b1, 8'hEF, 1'b0);
      step(1'b0, 8'h00, 1'b0);
      step(1'b0, 8'h00, 1'b0);

      // steady keystream, host keeps the queue topped up: all 256 values (R5..R8)
      wcount = 0;
      cyc = 0;
      while (wcount < 256) begin
         bit w;
         w = (q.size() < 8) && (cyc % 3 != 1);
         step(w, 8'(wcount), 1'b1);
         if (w) wcount++;
         cyc++;
      end
      // gapped keystream and occasional full-queue writes
      while (wcount < 320) begin
         bit w;
         w = (cyc % 4 == 0);
         step(w, 8'(wcount * 7 + 3), (cyc % 11) < 6);
         if (w && q.size() <= 8) wcount++;
         cyc++;
      end
      // drain, then idle
      while (q.size() != 0 || act) step(1'b0, 8'h00, 1'b1);
      for (int i = 0; i < 12; i++) step(1'b0, 8'h00, (i % 2) == 0);
      chk("R7 byte count", bytes_out, kidx);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule